// File: doc/BRIEF.md
# Dual-Channel Mirrored Interrupt Status

This block holds the interrupt status of two disk-controller channels and drives one shared, level-sensitive interrupt line. Each channel's request input sets its status bit when it rises and clears the bit when it falls. Software sees every status bit in two places: a legacy view and a combined mode view. Both views always read the same value, and a write of one to either view clears the bit for both.

The mode view also carries one block bit per channel. A set block bit keeps that channel's status off the interrupt line. A dword-wide configuration port with byte enables can read all views. Writes through that port can only clear status bits. A separate byte-wide DMA-window alias is the only path that can change the block bits.

Top module: `irq_mirror_ctl`

## Requirements
- R1: After reset, all status bits and both block bits read 0 and `irq_o` is low.
- R2: A rising edge on `req_i[c]` sets channel c's status. The status reads 1 in the legacy view and in the mode view from the next cycle. The legacy view is dword 0x14 bit 2 for channel 0 and dword 0x15 bit 28 for channel 1. The mode view is dword 0x1C bit 10+c, which is also bit 2+c of `dma_rdata_o`.
- R3: A falling edge on `req_i[c]` clears channel c's status in both views from the next cycle.
- R4: A configuration write to a legacy view clears that channel's status in both views. The write needs the byte enable of the status bit's byte set and a 1 in the status bit position.
- R5: A configuration write to dword 0x1C clears channel c's status in both views. The write needs byte enable 1 set and a 1 in data bit 10+c.
- R6: A configuration write never sets a status bit and never changes a block bit. A write with the relevant byte enable clear, or with a 0 in the status position, has no effect.
- R7: A DMA alias write loads the block bits from data bits 5:4 (bit 4 for channel 0, bit 5 for channel 1) and ignores all other data bits. The block bits read at dword 0x1C bits 13:12 and at `dma_rdata_o` bits 5:4.
- R8: `irq_o` is high exactly when at least one channel has its status set and its block bit clear.
- R9: When a rising edge on a channel's request and a clearing write to that channel's status arrive in the same cycle, the status ends set.
- R10: A request held high does not set its status again after software has cleared it. Only a new rising edge sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 2 | Per-channel interrupt request level |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 6 | Configuration dword address |
| cfg_be_i | input | 4 | Configuration byte enables |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data for `cfg_addr_i` (combinational) |
| dma_we_i | input | 1 | DMA alias write strobe |
| dma_wdata_i | input | 8 | DMA alias write data |
| dma_rdata_o | output | 8 | Mode byte as seen through the DMA alias |
| irq_o | output | 1 | Shared level interrupt |

## Verification
The hardest case to reach is a request edge that lands in the same cycle as a clearing write to the same channel. The random stimulus rarely lines these up. Directed steps first drop the request, then raise it in the very cycle that carries the clear. Both the legacy and the mode address are used for the clear. A request held high across later clears is also driven on purpose, to show that only edges set status. Random steps then mix request toggles, partial byte enables and alias writes against a reference model.

// File: rtl/irq_mirror_pkg.sv
package irq_mirror_pkg;
  localparam int NCH = 2;
  localparam int AW  = 6;
  localparam int DW  = 32;
  localparam int BW  = 8;
  localparam int NBE = DW / BW;

  localparam logic [AW-1:0] ADR_LEG0 = 6'h14;
  localparam logic [AW-1:0] ADR_LEG1 = 6'h15;
  localparam logic [AW-1:0] ADR_MODE = 6'h1C;

  // bit positions inside the dword
  localparam int LEG0_POS = 2;
  localparam int LEG1_POS = 28;
  localparam int MST_POS  = 10;
  localparam int MBK_POS  = 12;
  // bit positions inside the mode byte
  localparam int BST_POS  = 2;
  localparam int BBK_POS  = 4;

  function automatic int leg_pos(int c);
    return (c == 0) ? LEG0_POS : LEG1_POS;
  endfunction

  function automatic logic [AW-1:0] leg_adr(int c);
    return (c == 0) ? ADR_LEG0 : ADR_LEG1;
  endfunction
endpackage

// File: rtl/irq_req_edge.sv
module irq_req_edge #(
  parameter int NCH = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] req_i,
  output logic [NCH-1:0] rise_o,
  output logic [NCH-1:0] fall_o
);
  logic [NCH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= req_i;
  end

  assign rise_o = req_i & ~prev_q;
  assign fall_o = ~req_i & prev_q;
endmodule

// File: rtl/irq_cfg_decode.sv
module irq_cfg_decode
  import irq_mirror_pkg::*;
(
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [NBE-1:0] be_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [NCH-1:0] clr_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int LP = leg_pos(c);
    localparam int MP = MST_POS + c;
    logic leg_hit, mode_hit;
    assign leg_hit  = (addr_i == leg_adr(c)) && be_i[LP/BW] && wdata_i[LP];
    assign mode_hit = (addr_i == ADR_MODE)   && be_i[MP/BW] && wdata_i[MP];
    assign clr_o[c] = we_i && (leg_hit || mode_hit);
  end
endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank
  import irq_mirror_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] rise_i,
  input  logic [NCH-1:0] fall_i,
  input  logic [NCH-1:0] clr_i,
  input  logic           blk_we_i,
  input  logic [NCH-1:0] blk_d_i,
  output logic [NCH-1:0] stat_o,
  output logic [NCH-1:0] blk_o
);
  logic [NCH-1:0] stat_q, blk_q;

  // one flop per channel backs both software views; hardware set has priority
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      blk_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_i & ~fall_i) | rise_i;
      if (blk_we_i) blk_q <= blk_d_i;
    end
  end

  assign stat_o = stat_q;
  assign blk_o  = blk_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ast
    AST_RISE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_i[c] |=> stat_q[c]); // R9
    AST_FALL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_i[c] |=> !stat_q[c]); // R3
    AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[c] && !rise_i[c]) |=> !stat_q[c]); // R4
    AST_EDGE_ONLY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rise_i[c] |=> !$rose(stat_q[c])); // R10
  end

  AST_BLK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blk_we_i |=> $stable(blk_q)); // R6
endmodule

// File: rtl/irq_mirror_ctl.sv
module irq_mirror_ctl
  import irq_mirror_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] req_i,
  input  logic           cfg_we_i,
  input  logic [AW-1:0]  cfg_addr_i,
  input  logic [NBE-1:0] cfg_be_i,
  input  logic [DW-1:0]  cfg_wdata_i,
  output logic [DW-1:0]  cfg_rdata_o,
  input  logic           dma_we_i,
  input  logic [BW-1:0]  dma_wdata_i,
  output logic [BW-1:0]  dma_rdata_o,
  output logic           irq_o
);
  logic [NCH-1:0] rise, fall, clr, stat, blk;

  irq_req_edge #(.NCH(NCH)) i_edge (
    .clk_i, .rst_ni, .req_i, .rise_o(rise), .fall_o(fall)
  );

  irq_cfg_decode i_dec (
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .be_i(cfg_be_i),
    .wdata_i(cfg_wdata_i), .clr_o(clr)
  );

  irq_stat_bank i_bank (
    .clk_i, .rst_ni,
    .rise_i(rise), .fall_i(fall), .clr_i(clr),
    .blk_we_i(dma_we_i), .blk_d_i(dma_wdata_i[BBK_POS +: NCH]),
    .stat_o(stat), .blk_o(blk)
  );

  always_comb begin
    cfg_rdata_o = '0;
    unique case (cfg_addr_i)
      ADR_LEG0: cfg_rdata_o[LEG0_POS] = stat[0];
      ADR_LEG1: cfg_rdata_o[LEG1_POS] = stat[1];
      ADR_MODE: begin
        cfg_rdata_o[MST_POS +: NCH] = stat;
        cfg_rdata_o[MBK_POS +: NCH] = blk;
      end
      default: cfg_rdata_o = '0;
    endcase
  end

  always_comb begin
    dma_rdata_o = '0;
    dma_rdata_o[BST_POS +: NCH] = stat;
    dma_rdata_o[BBK_POS +: NCH] = blk;
  end

  assign irq_o = |(stat & ~blk);

  AST_IRQ_NEEDS_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (dma_rdata_o[BST_POS +: NCH] != '0)); // R8
  AST_IRQ_ALL_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_addr_i == ADR_MODE && cfg_rdata_o[MBK_POS +: NCH] == '1) |-> !irq_o); // R8
  AST_VIEWS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_addr_i == ADR_MODE) |-> (cfg_rdata_o[MST_POS +: NCH] == dma_rdata_o[BST_POS +: NCH])); // R2
endmodule

// File: tb/test_irq_mirror_ctl.sv
`timescale 1ns/1ps
module test_irq_mirror_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  req = '0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wd = '0;
  logic [31:0] cfg_rd;
  logic        dma_we = 1'b0;
  logic [7:0]  dma_wd = '0;
  logic [7:0]  dma_rd;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [1:0] m_stat = '0, m_blk = '0, m_prev = '0;

  always #2 clk = ~clk;

  irq_mirror_ctl i_irq_mirror_ctl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_be_i(cfg_be),
    .cfg_wdata_i(cfg_wd), .cfg_rdata_o(cfg_rd),
    .dma_we_i(dma_we), .dma_wdata_i(dma_wd), .dma_rdata_o(dma_rd),
    .irq_o(irq)
  );

  function automatic logic [31:0] exp_rd(logic [5:0] a);
    logic [31:0] v = '0;
    if (a == 6'h14) v[2] = m_stat[0];
    else if (a == 6'h15) v[28] = m_stat[1];
    else if (a == 6'h1C) begin
      v[11:10] = m_stat;
      v[13:12] = m_blk;
    end
    return v;
  endfunction

  function automatic logic exp_irq();
    return |(m_stat & ~m_blk);
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [5:0] adrs [4] = '{6'h14, 6'h15, 6'h1C, 6'h20};
    check({tag, " R8 irq"}, {31'b0, irq}, {31'b0, exp_irq()});
    check({tag, " R7 dma view"}, {24'b0, dma_rd}, {24'b0, 2'b0, m_blk, m_stat, 2'b0});
    foreach (adrs[i]) begin
      cfg_addr = adrs[i];
      #0.2;
      check($sformatf("%s cfg view %h", tag, adrs[i]), cfg_rd, exp_rd(adrs[i]));
    end
  endtask

  // apply one cycle of stimulus, update the model, then check
  task automatic step(string tag, logic [1:0] r, logic we, logic [5:0] a,
                      logic [3:0] be, logic [31:0] wd, logic dwe, logic [7:0] dwd);
    logic [1:0] rise, fall, clr;
    @(negedge clk);
    req = r; cfg_we = we; cfg_addr = a; cfg_be = be; cfg_wd = wd;
    dma_we = dwe; dma_wd = dwd;
    @(posedge clk);
    rise = r & ~m_prev;
    fall = ~r & m_prev;
    clr[0] = we && ((a == 6'h14 && be[0] && wd[2]) || (a == 6'h1C && be[1] && wd[10]));
    clr[1] = we && ((a == 6'h15 && be[3] && wd[28]) || (a == 6'h1C && be[1] && wd[11]));
    m_stat = (m_stat & ~clr & ~fall) | rise;
    if (dwe) m_blk = dwd[5:4];
    m_prev = r;
    #0.5;
    cfg_we = 1'b0; dma_we = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #5;
    check_all("R1 in reset");
    rst_n = 1'b1;
    #1;
    check_all("R1 after reset");

    step("R2 ch0 rise", 2'b01, 0, 0, 0, 0, 0, 0);
    step("R4 legacy clr ch0", 2'b01, 1, 6'h14, 4'b0001, 32'h4, 0, 0);
    step("R10 held no reset", 2'b01, 0, 0, 0, 0, 0, 0);
    step("R2 ch1 rise", 2'b11, 0, 0, 0, 0, 0, 0);
    step("R4 legacy clr ch1", 2'b11, 1, 6'h15, 4'b1000, 32'h1000_0000, 0, 0);
    step("R3 fall", 2'b00, 0, 0, 0, 0, 0, 0);
    step("R2 both rise", 2'b11, 0, 0, 0, 0, 0, 0);
    step("R6 be off", 2'b11, 1, 6'h1C, 4'b1101, 32'hFFFF_FFFF, 0, 0);
    step("R6 zero data", 2'b11, 1, 6'h14, 4'b1111, 32'hFFFF_FFFB, 0, 0);
    step("R6 no blk via cfg", 2'b11, 1, 6'h1C, 4'b0010, 32'h0000_3000, 0, 0);
    step("R7 dma blk ch0", 2'b11, 0, 0, 0, 0, 1, 8'hDF);
    step("R8 ch1 only", 2'b11, 0, 0, 0, 0, 0, 0);
    step("R7 dma blk all", 2'b11, 0, 0, 0, 0, 1, 8'h3C);
    step("R7 dma unblock", 2'b11, 0, 0, 0, 0, 1, 8'hCF);
    step("R5 mode clr ch1", 2'b11, 1, 6'h1C, 4'b0010, 32'h0000_0800, 0, 0);
    step("R5 mode clr ch0", 2'b11, 1, 6'h1C, 4'b0010, 32'h0000_0400, 0, 0);
    step("R3 drop both", 2'b00, 0, 0, 0, 0, 0, 0);
    step("R9 rise vs legacy clr", 2'b01, 1, 6'h14, 4'b0001, 32'h4, 0, 0);
    step("R9 rise vs mode clr", 2'b11, 1, 6'h1C, 4'b0010, 32'h0C00, 0, 0);

    for (int n = 0; n < 3000; n++) begin
      logic [5:0] a;
      logic [31:0] wd;
      logic [1:0] r;
      int sel = $urandom_range(0, 3);
      a = (sel == 0) ? 6'h14 : (sel == 1) ? 6'h15 : (sel == 2) ? 6'h1C : 6'($urandom);
      wd = $urandom;
      r = ($urandom_range(0, 3) == 0) ? 2'($urandom) : req;
      step("R2 R3 R4 R5 R6 random", r, 1'($urandom_range(0, 1)), a,
           4'($urandom), wd, ($urandom_range(0, 7) == 0), 8'($urandom));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule